// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller with Poll Service

This block is an eight-input interrupt controller with a byte-wide register interface. One address bit selects between a command port and a mask port. Software brings it up with a short initialization sequence. After that it masks lines, reads back the pending-request and in-service bytes, and ends interrupts with end-of-interrupt commands. The block drives one interrupt line toward the processor.

Requests are not delivered through a bus acknowledge cycle. Software arms a poll and then reads the command port. That read returns the winning level and also acknowledges it. If nothing is eligible, the read returns level 7 with the presence bit clear, and the in-service bit of level 7 stays clear. Software uses this to recognise a spurious interrupt.

Two copies can be chained. The interrupt output of one copy drives input 2 of the other. A cascaded interrupt is then serviced by polling the upper copy, which reports level 2, and then polling the lower copy. The lower copy's end-of-interrupt is issued before the upper copy's level-2 end-of-interrupt.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the block is uninitialized. Its interrupt output is low, the request, in-service and mask bytes are all zero, command reads return the request byte, and rising input edges are not recorded until initialization completes.
- R2: A command-port write with bit 4 set starts initialization. It clears the request, in-service and mask bytes, disarms poll and selects the request byte for reads. Later mask-port writes are then consumed in order: a vector byte; a link byte, only if bit 1 of the start byte was 0; a mode byte, only if bit 0 of the start byte was 1. The block then runs. Consumed bytes never change the mask.
- R3: While running, a mask-port write loads the mask byte (bit n = 1 masks line n), and a mask-port read returns it.
- R4: While running, a rising edge on input n sets request bit n. A line held high does not set the bit again.
- R5: The interrupt output is high exactly when the block runs and some line n has its request bit set, its mask bit clear, and no in-service bit set at any position from 0 to n. Level 0 has the highest priority.
- R6: Command write 0x0A selects the request byte and 0x0B selects the in-service byte for command-port reads. The selection persists across reads and polls.
- R7: Command write 0x0C arms poll. The next command read returns bit 7 = 1 and the winning level (as defined in R5) in bits 2:0. It sets that in-service bit, clears that request bit and disarms poll.
- R8: A poll read with no eligible request returns 0x07 and changes no in-service bit.
- R9: Command write 0x60+n clears in-service bit n only.
- R10: Command write 0x20 clears the lowest-numbered set in-service bit.
- R11: With one copy's output driving input 2 of another, a request on the lower copy raises the upper output two clocks after the edge. Polls return level 2 from the upper copy and then the lower level. End-of-interrupt on both copies returns both in-service bytes to zero.
- R12: With chip select low, writes and reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for both ports |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| a0 | input | 1 | Port select: 0 command, 1 mask |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected port, combinational |
| irq_in | input | 8 | Interrupt request lines, edge sensitive |
| int_out | output | 1 | Interrupt toward the processor |

## Verification
Writes and the acknowledge side of a poll read take effect at the clock edge that ends the strobe cycle. The read data itself reflects the state before that edge. An input edge presented in one cycle shows in the request byte and in the interrupt output after the next edge. Through a cascade, the upper output follows one edge later. The bench drives all stimulus on falling edges and captures read data one nanosecond after the falling edge that opens the read. A behavioural model advances on each rising edge, and both copies' outputs are compared against it two nanoseconds later, so every comparison sees settled values.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int LINES = 8;
    localparam int LVL_W = $clog2(LINES);

    typedef enum logic [2:0] {
        PH_RAW,
        PH_VEC,
        PH_LINK,
        PH_MODE,
        PH_RUN
    } phase_e;

    typedef enum logic [2:0] {
        CMD_START,
        CMD_EOI_LVL,
        CMD_EOI_TOP,
        CMD_SEL,
        CMD_OTHER
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e          kind;
        logic [LVL_W-1:0]   lvl;
        logic               want_mode;
        logic               solo;
        logic               poll;
        logic               sel_upd;
        logic               sel_isr;
    } cmd_t;
endpackage

// File: rtl/pic8_cmd_dec.sv
module pic8_cmd_dec
    import pic8_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_t       cmd_o
);
    always_comb begin
        cmd_o.kind = CMD_OTHER;
        if (cmd_byte[4]) begin
            cmd_o.kind = CMD_START;
        end else if (cmd_byte[3]) begin
            cmd_o.kind = CMD_SEL;
        end else if (cmd_byte[7:5] == 3'b011) begin
            cmd_o.kind = CMD_EOI_LVL;
        end else if (cmd_byte[7:5] == 3'b001) begin
            cmd_o.kind = CMD_EOI_TOP;
        end
        cmd_o.lvl       = cmd_byte[LVL_W-1:0];
        cmd_o.want_mode = cmd_byte[0];
        cmd_o.solo      = cmd_byte[1];
        cmd_o.poll      = cmd_byte[2];
        cmd_o.sel_upd   = cmd_byte[1];
        cmd_o.sel_isr   = cmd_byte[0];
    end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  blk,
    output logic          hit,
    output logic [LW-1:0] lvl
);
    logic stop_c;

    always_comb begin
        hit    = 1'b0;
        lvl    = '0;
        stop_c = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!stop_c) begin
                if (blk[i]) begin
                    stop_c = 1'b1;
                end else if (req[i]) begin
                    hit    = 1'b1;
                    lvl    = LW'(i);
                    stop_c = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             a0,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [LINES-1:0] irq_in,
    output logic             int_out
);
    typedef struct packed {
        phase_e             phase;
        logic               need_link;
        logic               need_mode;
        logic [LINES-1:0]   irr;
        logic [LINES-1:0]   isr;
        logic [LINES-1:0]   imr;
        logic [LINES-1:0]   prev;
        logic               poll_arm;
        logic               sel_isr;
    } st_t;

    st_t s_q, s_d;

    cmd_t             cmd;
    logic             wr_cmd, wr_msk, rd_cmd, running;
    logic [LINES-1:0] rise;
    logic             hit, top_hit;
    logic [LVL_W-1:0] lvl, top_lvl;

    assign wr_cmd  = cs && wr_en && !a0;
    assign wr_msk  = cs && wr_en && a0;
    assign rd_cmd  = cs && rd_en && !wr_en && !a0;
    assign running = (s_q.phase == PH_RUN);
    assign rise    = irq_in & ~s_q.prev;

    pic8_cmd_dec u_dec (
        .cmd_byte (wdata),
        .cmd_o    (cmd)
    );

    pic8_prio #(.N(LINES), .LW(LVL_W)) u_win (
        .req (s_q.irr & ~s_q.imr),
        .blk (s_q.isr),
        .hit (hit),
        .lvl (lvl)
    );

    pic8_prio #(.N(LINES), .LW(LVL_W)) u_top (
        .req (s_q.isr),
        .blk ('0),
        .hit (top_hit),
        .lvl (top_lvl)
    );

    assign int_out = running && hit;

    always_comb begin
        if (a0) begin
            rdata = s_q.imr;
        end else if (s_q.poll_arm) begin
            rdata = {hit, 4'b0000, (hit ? lvl : LVL_W'(LINES - 1))};
        end else if (s_q.sel_isr) begin
            rdata = s_q.isr;
        end else begin
            rdata = s_q.irr;
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.prev = irq_in;

        if (rd_cmd && s_q.poll_arm) begin
            s_d.poll_arm = 1'b0;
            if (hit) begin
                s_d.isr[lvl] = 1'b1;
                s_d.irr[lvl] = 1'b0;
            end
        end

        if (running) begin
            s_d.irr = s_d.irr | rise;
        end

        if (wr_cmd) begin
            case (cmd.kind)
                CMD_START: begin
                    s_d.phase     = PH_VEC;
                    s_d.need_link = !cmd.solo;
                    s_d.need_mode = cmd.want_mode;
                    s_d.irr       = '0;
                    s_d.isr       = '0;
                    s_d.imr       = '0;
                    s_d.poll_arm  = 1'b0;
                    s_d.sel_isr   = 1'b0;
                end
                CMD_EOI_LVL: if (running) s_d.isr[cmd.lvl] = 1'b0;
                CMD_EOI_TOP: if (running && top_hit) s_d.isr[top_lvl] = 1'b0;
                CMD_SEL: if (running) begin
                    if (cmd.poll)    s_d.poll_arm = 1'b1;
                    if (cmd.sel_upd) s_d.sel_isr  = cmd.sel_isr;
                end
                default: ;
            endcase
        end

        if (wr_msk) begin
            case (s_q.phase)
                PH_VEC:  s_d.phase = s_q.need_link ? PH_LINK
                                   : (s_q.need_mode ? PH_MODE : PH_RUN);
                PH_LINK: s_d.phase = s_q.need_mode ? PH_MODE : PH_RUN;
                PH_MODE: s_d.phase = PH_RUN;
                PH_RUN:  s_d.imr   = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_RAW, need_link: 1'b0, need_mode: 1'b0,
                     irr: '0, isr: '0, imr: '0, prev: '0,
                     poll_arm: 1'b0, sel_isr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    // R2: the mask stays clear until the block runs
    a_r2_mask_clear_in_init: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_RUN) |-> (s_q.imr == '0));

    // R4: every rising edge seen while running lands in the request byte
    a_r4_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (rise != '0) && !(wr_cmd && cmd.kind == CMD_START))
        |=> ((s_q.irr & $past(rise)) == $past(rise)));

    // R7: a poll read with a winner acknowledges it and disarms
    a_r7_poll_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && s_q.poll_arm && hit) |=> (s_q.isr[$past(lvl)] && !s_q.poll_arm));

    // R8: an empty poll leaves the in-service byte alone
    a_r8_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && s_q.poll_arm && !hit) |=> $stable(s_q.isr));

    // R9: specific end-of-interrupt clears its level
    a_r9_spec_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_cmd && cmd.kind == CMD_EOI_LVL) |=> !s_q.isr[$past(cmd.lvl)]);

    // R12: no chip select, no change of programmed state
    a_r12_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> ($stable(s_q.isr) && $stable(s_q.imr) && $stable(s_q.phase)));
endmodule

// File: tb/pic8_ctrl_tb_top.sv
module pic8_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_m = 1'b0, cs_s = 1'b0, wr_en = 1'b0, rd_en = 1'b0, a0 = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata_m, rdata_s;
    logic [7:0] ext_m = 8'h00;
    logic [7:0] irq_s = 8'h00;
    logic       int_m, int_s;
    logic [7:0] pins_m;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign pins_m = {ext_m[7:3], int_s, ext_m[1:0]};

    pic8_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs_m), .wr_en(wr_en), .rd_en(rd_en),
        .a0(a0), .wdata(wdata), .rdata(rdata_m), .irq_in(pins_m), .int_out(int_m)
    );

    pic8_ctrl slv_i (
        .clk(clk), .rst_n(rst_n), .cs(cs_s), .wr_en(wr_en), .rd_en(rd_en),
        .a0(a0), .wdata(wdata), .rdata(rdata_s), .irq_in(irq_s), .int_out(int_s)
    );

    // behavioural reference: index 0 upper copy, index 1 lower copy
    bit [7:0] q_irr[2], q_isr[2], q_imr[2], q_prev[2];
    int       q_phase[2];
    bit       q_link[2], q_mode[2], q_poll[2], q_selisr[2];

    function automatic int mdl_pick(int c);
        for (int i = 0; i < 8; i++) begin
            if (q_isr[c][i]) return -1;
            if (q_irr[c][i] && !q_imr[c][i]) return i;
        end
        return -1;
    endfunction

    function automatic bit mdl_int(int c);
        return (q_phase[c] == 4) && (mdl_pick(c) >= 0);
    endfunction

    function automatic bit [7:0] mdl_read(int c);
        int p;
        if (a0) return q_imr[c];
        if (q_poll[c]) begin
            p = mdl_pick(c);
            return (p >= 0) ? (8'h80 | 8'(p)) : 8'h07;
        end
        return q_selisr[c] ? q_isr[c] : q_irr[c];
    endfunction

    task automatic mdl_step(int c, bit [7:0] pins, bit sel);
        int p;
        bit run;
        bit [7:0] rise;
        p = mdl_pick(c);
        run = (q_phase[c] == 4);
        rise = pins & ~q_prev[c];
        q_prev[c] = pins;
        if (sel && rd_en && !wr_en && !a0 && q_poll[c]) begin
            q_poll[c] = 0;
            if (p >= 0) begin
                q_isr[c][p] = 1;
                q_irr[c][p] = 0;
            end
        end
        if (run) q_irr[c] = q_irr[c] | rise;
        if (sel && wr_en && !a0) begin
            if (wdata[4]) begin
                q_phase[c] = 1; q_link[c] = !wdata[1]; q_mode[c] = wdata[0];
                q_irr[c] = 0; q_isr[c] = 0; q_imr[c] = 0; q_poll[c] = 0; q_selisr[c] = 0;
            end else if (run) begin
                if (wdata[3]) begin
                    if (wdata[2]) q_poll[c] = 1;
                    if (wdata[1]) q_selisr[c] = wdata[0];
                end else if (wdata[7:5] == 3'b011) begin
                    q_isr[c][wdata[2:0]] = 0;
                end else if (wdata[7:5] == 3'b001) begin
                    for (int i = 0; i < 8; i++) begin
                        if (q_isr[c][i]) begin
                            q_isr[c][i] = 0;
                            break;
                        end
                    end
                end
            end
        end else if (sel && wr_en && a0) begin
            if (q_phase[c] == 1) q_phase[c] = q_link[c] ? 2 : (q_mode[c] ? 3 : 4);
            else if (q_phase[c] == 2) q_phase[c] = q_mode[c] ? 3 : 4;
            else if (q_phase[c] == 3) q_phase[c] = 4;
            else if (q_phase[c] == 4) q_imr[c] = wdata;
        end
    endtask

    always @(posedge clk) begin
        bit [7:0] pm;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                q_irr[c] = 0; q_isr[c] = 0; q_imr[c] = 0; q_prev[c] = 0;
                q_phase[c] = 0; q_link[c] = 0; q_mode[c] = 0; q_poll[c] = 0; q_selisr[c] = 0;
            end
        end else begin
            pm = {ext_m[7:3], mdl_int(1), ext_m[1:0]};
            mdl_step(1, irq_s, cs_s);
            mdl_step(0, pm, cs_m);
        end
    end

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            total += 2;
            if (int_m !== mdl_int(0)) begin
                bad++;
                $display("FAIL R5 upper int got=%0d exp=%0d t=%0t", int_m, mdl_int(0), $time);
            end
            if (int_s !== mdl_int(1)) begin
                bad++;
                $display("FAIL R11 lower int got=%0d exp=%0d t=%0t", int_s, mdl_int(1), $time);
            end
            total += 2;
            if (rdata_m !== mdl_read(0)) begin
                bad++;
                $display("FAIL R3/R6/R7 upper rdata got=%h exp=%h t=%0t", rdata_m, mdl_read(0), $time);
            end
            if (rdata_s !== mdl_read(1)) begin
                bad++;
                $display("FAIL R3/R6/R7 lower rdata got=%h exp=%h t=%0t", rdata_s, mdl_read(1), $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input bit sm, input bit ss, input bit a, input logic [7:0] d);
        @(negedge clk);
        cs_m = sm; cs_s = ss; a0 = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        cs_m = 1'b0; cs_s = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input bit slave, input bit a, output logic [7:0] v);
        @(negedge clk);
        cs_m = !slave; cs_s = slave; a0 = a; rd_en = 1'b1;
        #1 v = slave ? rdata_s : rdata_m;
        @(negedge clk);
        cs_m = 1'b0; cs_s = 1'b0; rd_en = 1'b0;
    endtask

    task automatic chk_int(input string tag, input logic exp);
        @(negedge clk);
        #1 chk(tag, {7'b0, int_m}, {7'b0, exp});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;

        // R1: reset state and edges ignored before initialization
        rd(0, 0, v); chk("R1 request byte after reset", v, 8'h00);
        rd(0, 1, v); chk("R1 mask after reset", v, 8'h00);
        chk_int("R1 output low after reset", 1'b0);
        @(negedge clk); ext_m[0] = 1'b1;
        idle(2); ext_m[0] = 1'b0;
        rd(0, 0, v); chk("R1 edge before init not recorded", v, 8'h00);

        // R2: the three sequence variants
        wr(1, 0, 0, 8'h12); wr(1, 0, 1, 8'h20);
        wr(1, 0, 1, 8'h5A); rd(0, 1, v); chk("R2 single without mode byte", v, 8'h5A);
        wr(1, 0, 0, 8'h10); rd(0, 1, v); chk("R2 start clears mask", v, 8'h00);
        wr(1, 0, 1, 8'h20); wr(1, 0, 1, 8'h04);
        wr(1, 0, 1, 8'h3C); rd(0, 1, v); chk("R2 cascade without mode byte", v, 8'h3C);
        wr(1, 0, 0, 8'h11); wr(1, 0, 1, 8'h20);
        rd(0, 1, v); chk("R2 vector byte not in mask", v, 8'h00);
        wr(1, 0, 1, 8'h04); wr(1, 0, 1, 8'h01);
        wr(0, 1, 0, 8'h11); wr(0, 1, 1, 8'h28); wr(0, 1, 1, 8'h02); wr(0, 1, 1, 8'h01);

        // R3: mask load and readback
        wr(1, 0, 1, 8'hA5); rd(0, 1, v); chk("R3 mask readback", v, 8'hA5);
        wr(1, 0, 1, 8'h00);

        // R12: strobes with no chip select
        wr(0, 0, 1, 8'hFF); rd(0, 1, v); chk("R12 deselected write ignored", v, 8'h00);

        // R4, R7, R6
        @(negedge clk); ext_m[5] = 1'b1;
        rd(0, 0, v); chk("R4 edge sets request", v, 8'h20);
        chk_int("R5 output high for pending line", 1'b1);
        wr(1, 0, 0, 8'h0C); rd(0, 0, v); chk("R7 poll returns level 5", v, 8'h85);
        rd(0, 0, v); chk("R7 poll one-shot, request cleared", v, 8'h00);
        idle(3);
        rd(0, 0, v); chk("R4 held line does not retrigger", v, 8'h00);
        wr(1, 0, 0, 8'h0B); rd(0, 0, v); chk("R6 in-service select", v, 8'h20);
        rd(0, 0, v); chk("R6 select persists", v, 8'h20);

        // R5 blocking, R9, R10
        @(negedge clk); ext_m[6] = 1'b1;
        chk_int("R5 lower priority blocked by in-service", 1'b0);
        @(negedge clk); ext_m[3] = 1'b1;
        chk_int("R5 higher priority passes", 1'b1);
        wr(1, 0, 0, 8'h0C); rd(0, 0, v); chk("R7 poll returns level 3", v, 8'h83);
        rd(0, 0, v); chk("R6 select survives poll", v, 8'h28);
        wr(1, 0, 0, 8'h63); rd(0, 0, v); chk("R9 specific eoi level 3", v, 8'h20);
        chk_int("R5 still blocked by level 5", 1'b0);
        wr(1, 0, 0, 8'h20); rd(0, 0, v); chk("R10 non-specific eoi", v, 8'h00);
        chk_int("R5 level 6 released", 1'b1);
        wr(1, 0, 0, 8'h0C); rd(0, 0, v); chk("R7 poll returns level 6", v, 8'h86);
        wr(1, 0, 0, 8'h66); rd(0, 0, v); chk("R9 specific eoi level 6", v, 8'h00);
        @(negedge clk); ext_m = 8'h00;

        // R8: masked line gives a spurious poll
        wr(1, 0, 1, 8'h02);
        @(negedge clk); ext_m[1] = 1'b1;
        wr(1, 0, 0, 8'h0A); rd(0, 0, v); chk("R4 masked line still recorded", v, 8'h02);
        chk_int("R5 masked line no output", 1'b0);
        wr(1, 0, 0, 8'h0C); rd(0, 0, v); chk("R8 spurious poll value", v, 8'h07);
        wr(1, 0, 0, 8'h0B); rd(0, 0, v); chk("R8 in-service untouched", v, 8'h00);
        wr(1, 0, 1, 8'h00);
        chk_int("R5 unmask raises output", 1'b1);
        wr(1, 0, 0, 8'h0C); rd(0, 0, v); chk("R7 poll returns level 1", v, 8'h81);
        wr(1, 0, 0, 8'h61);
        @(negedge clk); ext_m[1] = 1'b0;

        // R11: two-level cascade
        @(negedge clk); irq_s[4] = 1'b1;
        idle(2);
        chk_int("R11 cascaded request reaches upper output", 1'b1);
        wr(1, 0, 0, 8'h0C); rd(0, 0, v); chk("R11 upper poll reports link level", v, 8'h82);
        wr(0, 1, 0, 8'h0C); rd(1, 0, v); chk("R11 lower poll reports level 4", v, 8'h84);
        wr(0, 1, 0, 8'h0B); rd(1, 0, v); chk("R11 lower in-service", v, 8'h10);
        chk_int("R11 upper output low while serviced", 1'b0);
        wr(0, 1, 0, 8'h64); wr(1, 0, 0, 8'h62);
        rd(0, 0, v); chk("R11 upper in-service cleared", v, 8'h00);
        rd(1, 0, v); chk("R11 lower in-service cleared", v, 8'h00);

        idle(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R1 watchdog got=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule